// File: doc/BRIEF.md
# Floppy Head Seek Step Sequencer

This block moves a floppy drive head by a commanded number of tracks. A one-cycle start request carries a track count, a direction and a recalibrate flag. The sequencer then asserts the active-low drive select, sets the direction line and issues one active-low step pulse per track. Each step has a fixed shape: a direction setup interval, a low pulse, a spacing to the next step, and a final hold before the select is released. Every interval is counted in MCLK periods. MCLK is supplied as a one-clock enable pulse, `mclk_tick`, at sixteen times the selected data rate, so a change of data rate scales all the timing together.

In recalibrate mode the commanded count and direction are ignored. The head is stepped outward until the active-low track-zero input reports the outermost track. The sequence ends with an error if track zero is still not seen after a fixed number of steps. Completion is reported by a one-clock `done` pulse, with `seek_err` qualifying it.

Top module: `seek_stepper`

## Requirements
- R1: After reset, `step_n` and `sel_n` are high, and `busy`, `done` and `seek_err` are low.
- R2: `dir_out` is 1 for outward motion and 0 for inward motion. On an accepted start it takes `move_out`, or 1 when `recal` is set. It does not change while `sel_n` is low.
- R3: The first step pulse of a seek falls no fewer than 4 `mclk_tick` periods after `sel_n` goes low.
- R4: Every step pulse stays low for exactly 24 `mclk_tick` periods, and `step_n` only falls in a cycle that follows a tick.
- R5: Successive falling edges of `step_n` within one seek are exactly 132 tick periods apart.
- R6: A non-recalibrate seek issues exactly `step_count` step pulses. A count of zero raises `done` in the cycle after the start is accepted, with no step pulse and no assertion of `sel_n`.
- R7: `done` is a single-cycle pulse. It comes at least 96 ticks after the last rising edge of `step_n` and at least 20 ticks after its last falling edge. `sel_n` is high in the `done` cycle, and a step pulse occurs only while `sel_n` is low.
- R8: In recalibrate mode, `trk0_n` is checked before each step. Outward steps continue until `trk0_n` is low. If it is already low, no step is issued. In both cases `seek_err` stays low at `done`.
- R9: If `trk0_n` is still high after 80 recalibrate steps, the sequence ends with `done` and `seek_err` high together.
- R10: A start request while `busy` is high is ignored: the step count and direction of the running seek are unchanged, and no further seek follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mclk_tick | input | 1 | One-clock enable, one per MCLK period |
| start | input | 1 | Start request, one clock |
| step_count | input | CNT_W | Number of tracks to move |
| move_out | input | 1 | Requested direction, 1 = outward |
| recal | input | 1 | Run the recalibrate sequence instead |
| trk0_n | input | 1 | Track-zero sense, low at the outermost track |
| step_n | output | 1 | Step pulse, active low |
| dir_out | output | 1 | Head direction, 1 = outward |
| sel_n | output | 1 | Drive select, active low |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-clock completion pulse |
| seek_err | output | 1 | Recalibrate failure, valid with done |

## Verification
Any wrong phase or tick count in the sequencer shows up at the ports within one step period. A step pulse that is too short or too long, or a spacing other than 132 ticks, appears on the next rising or falling edge of `step_n`. A wrong step tally shows at `done` as an extra or missing pulse, which the bench compares with a head-position model driving `trk0_n`. A latched command or direction that is corrupted shows as a direction change under select, or as a wrong total, by the end of that same seek.

// File: rtl/seek_pkg.sv
// Shared types for the seek step sequencer.
// Assumes: nothing beyond IEEE 1800-2017 enum support.
package seek_pkg;

    // Phases of one seek sequence.
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SETUP = 3'd1,
        PH_LOW   = 3'd2,
        PH_GAP   = 3'd3,
        PH_HOLD  = 3'd4,
        PH_DONE  = 3'd5
    } seek_phase_t;

endpackage

// File: rtl/seek_tick_timer.sv
// Phase interval timer: counts mclk ticks and flags the tick that ends an
// interval of `len` ticks. It restarts itself on that tick.
// Assumes: len >= 1 and len is held constant within one interval.
module seek_tick_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          tick,
    input  logic [TW-1:0] len,
    output logic          expire
);
    logic [TW-1:0] cnt;

    // End of interval: the tick that completes `len` ticks.
    assign expire = tick && (cnt == len - 1'b1);

    // Tick counter, cleared when idle or at interval end.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= expire ? '0 : cnt + 1'b1;
        end
    end

    AST_TIMER_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |-> (cnt < len)); // R4

endmodule

// File: rtl/seek_step_tally.sv
// Step tally: counts issued step pulses of the current seek and compares
// them with the commanded count and with the recalibrate step limit.
// Assumes: clear and inc are never high together.
module seek_step_tally #(
    parameter int CNT_W     = 8,
    parameter int MAX_RECAL = 80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    input  logic [CNT_W-1:0] target,
    output logic             reached,
    output logic             at_limit
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_RECAL);

    logic [CNT_W-1:0] issued;

    // Compare against the commanded count and the recalibrate limit.
    assign reached  = (issued == target);
    assign at_limit = (issued == LIMIT);

    // Issued-step counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            issued <= '0;
        end else if (inc) begin
            issued <= issued + 1'b1;
        end
    end

    AST_NO_TALLY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> (issued != {CNT_W{1'b1}})); // R6

endmodule

// File: rtl/seek_seq_ctrl.sv
// Sequencer control: accepts a command, walks the setup / low / gap / hold
// phases, and drives the step, direction, select and completion outputs.
// Assumes: the timer restarts at each phase end and is cleared when idle;
// the tally is cleared when a command is accepted.
module seek_seq_ctrl
    import seek_pkg::*;
#(
    parameter int           CNT_W     = 8,
    parameter int           TW        = 8,
    parameter logic [TW-1:0] SETUP_LEN = 4,
    parameter logic [TW-1:0] LOW_LEN   = 24,
    parameter logic [TW-1:0] GAP_LEN   = 108,
    parameter logic [TW-1:0] FINAL_LEN = 96
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic [CNT_W-1:0] step_count,
    input  logic             move_out,
    input  logic             recal,
    input  logic             trk0_n,
    input  logic             expire,
    input  logic             reached,
    input  logic             at_limit,
    output logic             timer_clear,
    output logic [TW-1:0]    len,
    output logic             tally_clear,
    output logic             tally_inc,
    output logic [CNT_W-1:0] target,
    output logic             step_n,
    output logic             dir_out,
    output logic             sel_n,
    output logic             busy,
    output logic             done,
    output logic             seek_err
);
    seek_phase_t st, nxt;
    logic        recal_q;
    logic        step_q, sel_q, dir_q, err_q;
    logic        accept, step_fall, step_rise, err_next, more;

    // Another step is due: recalibrate until track zero or the limit.
    assign more = recal_q ? (trk0_n && !at_limit) : !reached;

    // Next phase and the events raised on each transition.
    always_comb begin
        nxt       = st;
        accept    = 1'b0;
        step_fall = 1'b0;
        step_rise = 1'b0;
        err_next  = 1'b0;
        case (st)
            PH_IDLE: begin
                if (start) begin
                    accept = 1'b1;
                    nxt    = (!recal && step_count == '0) ? PH_DONE : PH_SETUP;
                end
            end
            PH_SETUP: begin
                if (expire) begin
                    if (more) begin
                        nxt       = PH_LOW;
                        step_fall = 1'b1;
                    end else begin
                        nxt = PH_DONE;
                    end
                end
            end
            PH_LOW: begin
                if (expire) begin
                    step_rise = 1'b1;
                    nxt       = (!recal_q && reached) ? PH_HOLD : PH_GAP;
                end
            end
            PH_GAP: begin
                if (expire) begin
                    if (more) begin
                        nxt       = PH_LOW;
                        step_fall = 1'b1;
                    end else begin
                        nxt      = PH_DONE;
                        err_next = recal_q && trk0_n && at_limit;
                    end
                end
            end
            PH_HOLD: begin
                if (expire) nxt = PH_DONE;
            end
            PH_DONE: nxt = PH_IDLE;
            default: nxt = PH_IDLE;
        endcase
    end

    // Interval length of the current phase.
    always_comb begin
        case (st)
            PH_SETUP: len = SETUP_LEN;
            PH_LOW:   len = LOW_LEN;
            PH_GAP:   len = GAP_LEN;
            PH_HOLD:  len = FINAL_LEN;
            default:  len = TW'(1);
        endcase
    end

    // Phase register, latched command and registered drive outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= PH_IDLE;
            target  <= '0;
            recal_q <= 1'b0;
            dir_q   <= 1'b1;
            step_q  <= 1'b1;
            sel_q   <= 1'b1;
            err_q   <= 1'b0;
        end else begin
            st <= nxt;
            if (accept) begin
                target  <= step_count;
                recal_q <= recal;
                dir_q   <= recal ? 1'b1 : move_out;
                sel_q   <= !recal && (step_count == '0);
                err_q   <= 1'b0;
            end
            if (step_fall) step_q <= 1'b0;
            if (step_rise) step_q <= 1'b1;
            if (nxt == PH_DONE && st != PH_DONE) begin
                sel_q <= 1'b1;
                err_q <= err_next;
            end
        end
    end

    assign timer_clear = (st == PH_IDLE) || (st == PH_DONE);
    assign tally_clear = accept;
    assign tally_inc   = step_fall;
    assign step_n      = step_q;
    assign dir_out     = dir_q;
    assign sel_n       = sel_q;
    assign busy        = (st != PH_IDLE);
    assign done        = (st == PH_DONE);
    assign seek_err    = done && err_q;

    AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_q && $past(!sel_q)) |-> $stable(dir_q)); // R2
    AST_STEP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(step_q) |-> $past(tick)); // R4
    AST_STEP_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        !step_q |-> !sel_q); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_RECAL_OUTWARD: assert property (@(posedge clk) disable iff (!rst_n)
        (recal_q && !sel_q) |-> dir_q); // R8
    AST_ERR_ONLY_RECAL: assert property (@(posedge clk) disable iff (!rst_n)
        seek_err |-> recal_q); // R9
    AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(target) && $stable(dir_q))); // R10

endmodule

// File: rtl/seek_stepper.sv
// Floppy head seek step sequencer, top level. Wires the phase timer, the
// step tally and the control sequencer; derives phase lengths from the
// timing parameters, all in mclk_tick periods.
// Assumes: mclk_tick is a one-clock enable, one pulse per MCLK period;
// CYCLE_TICKS > LOW_TICKS; MAX_RECAL fits in CNT_W bits.
module seek_stepper #(
    parameter int CNT_W          = 8,
    parameter int SETUP_TICKS    = 4,
    parameter int LOW_TICKS      = 24,
    parameter int DIR_HOLD_TICKS = 96,
    parameter int CYCLE_TICKS    = 132,
    parameter int SEL_HOLD_TICKS = 20,
    parameter int MAX_RECAL      = 80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mclk_tick,
    input  logic             start,
    input  logic [CNT_W-1:0] step_count,
    input  logic             move_out,
    input  logic             recal,
    input  logic             trk0_n,
    output logic             step_n,
    output logic             dir_out,
    output logic             sel_n,
    output logic             busy,
    output logic             done,
    output logic             seek_err
);
    localparam int GAP_TICKS   = CYCLE_TICKS - LOW_TICKS;
    localparam int SEL_AFTER   = SEL_HOLD_TICKS - LOW_TICKS;
    localparam int FINAL_TICKS = (DIR_HOLD_TICKS > SEL_AFTER) ? DIR_HOLD_TICKS : SEL_AFTER;
    localparam int MAX_A       = (SETUP_TICKS > LOW_TICKS) ? SETUP_TICKS : LOW_TICKS;
    localparam int MAX_B       = (GAP_TICKS > FINAL_TICKS) ? GAP_TICKS : FINAL_TICKS;
    localparam int MAX_LEN     = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int TW          = $clog2(MAX_LEN + 1);

    logic             timer_clear, expire;
    logic [TW-1:0]    len;
    logic             tally_clear, tally_inc, reached, at_limit;
    logic [CNT_W-1:0] target;

    seek_tick_timer #(.TW(TW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (timer_clear),
        .tick   (mclk_tick),
        .len    (len),
        .expire (expire)
    );

    seek_step_tally #(.CNT_W(CNT_W), .MAX_RECAL(MAX_RECAL)) u_tally (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (tally_clear),
        .inc      (tally_inc),
        .target   (target),
        .reached  (reached),
        .at_limit (at_limit)
    );

    seek_seq_ctrl #(
        .CNT_W     (CNT_W),
        .TW        (TW),
        .SETUP_LEN (TW'(SETUP_TICKS)),
        .LOW_LEN   (TW'(LOW_TICKS)),
        .GAP_LEN   (TW'(GAP_TICKS)),
        .FINAL_LEN (TW'(FINAL_TICKS))
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (mclk_tick),
        .start       (start),
        .step_count  (step_count),
        .move_out    (move_out),
        .recal       (recal),
        .trk0_n      (trk0_n),
        .expire      (expire),
        .reached     (reached),
        .at_limit    (at_limit),
        .timer_clear (timer_clear),
        .len         (len),
        .tally_clear (tally_clear),
        .tally_inc   (tally_inc),
        .target      (target),
        .step_n      (step_n),
        .dir_out     (dir_out),
        .sel_n       (sel_n),
        .busy        (busy),
        .done        (done),
        .seek_err    (seek_err)
    );

    AST_DONE_IDLE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> sel_n); // R7

endmodule

// File: tb/seek_stepper_test.sv
// Self-checking bench: random tick spacing and random seeks, plus directed
// zero-count, busy-start and recalibrate corner cases. A head-position
// model drives trk0_n from the observed step pulses.
module seek_stepper_test;
    localparam int CNT_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mclk_tick = 1'b0;
    logic start = 1'b0;
    logic [CNT_W-1:0] step_count = '0;
    logic move_out = 1'b0;
    logic recal = 1'b0;
    logic trk0_n = 1'b0;
    logic step_n, dir_out, sel_n, busy, done, seek_err;

    int checks = 0;
    int errors = 0;
    int tcount = 0;
    int head = 0;
    bit exp_dir = 1'b1;
    int falls, last_fall, last_rise, first_fall, sel_tick;
    int width_bad, space_bad, dir_bad, done_wide, done_tick;
    bit done_seen, done_err, sel_seen, sel_at_done;
    bit prev_step = 1'b1, prev_sel = 1'b1, prev_dir = 1'b1, prev_done = 1'b0;

    seek_stepper uut (
        .clk(clk), .rst_n(rst_n), .mclk_tick(mclk_tick), .start(start),
        .step_count(step_count), .move_out(move_out), .recal(recal),
        .trk0_n(trk0_n), .step_n(step_n), .dir_out(dir_out), .sel_n(sel_n),
        .busy(busy), .done(done), .seek_err(seek_err)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_stats();
        falls = 0; last_fall = 0; last_rise = 0; first_fall = 0; sel_tick = 0;
        width_bad = 0; space_bad = 0; dir_bad = 0; done_wide = 0; done_tick = 0;
        done_seen = 0; done_err = 0; sel_seen = 0; sel_at_done = 0;
    endtask

    // Observer, head model and tick generator, all at the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_sel && !sel_n) begin
                sel_seen = 1;
                sel_tick = tcount;
            end
            if (!sel_n && !prev_sel && dir_out != prev_dir) dir_bad++;
            if (prev_step && !step_n) begin
                if (falls > 0 && tcount - last_fall != 132) space_bad++;
                if (falls == 0) first_fall = tcount;
                last_fall = tcount;
                falls++;
                if (dir_out != exp_dir) dir_bad++;
                if (dir_out) head = (head > 0) ? head - 1 : 0;
                else head = head + 1;
            end
            if (!prev_step && step_n) begin
                last_rise = tcount;
                if (tcount - last_fall != 24) width_bad++;
            end
            if (done) begin
                if (prev_done) done_wide++;
                done_seen = 1;
                done_tick = tcount;
                done_err = seek_err;
                sel_at_done = sel_n;
            end
        end
        prev_step = step_n;
        prev_sel = sel_n;
        prev_dir = dir_out;
        prev_done = done;
        trk0_n = (head != 0);
        mclk_tick = ($urandom_range(0, 1) == 1);
        if (mclk_tick) tcount++;
    end

    // Run one sequence; optionally poke a start while busy (R10).
    task automatic run_seek(input int cnt, input bit dir, input bit rc,
                            input int exp_steps, input bit exp_err, input bit poke);
        @(posedge clk); #1;
        clear_stats();
        exp_dir = rc ? 1'b1 : dir;
        start = 1; step_count = CNT_W'(cnt); move_out = dir; recal = rc;
        @(posedge clk); #1;
        start = 0;
        if (poke) begin
            while (falls < 1) @(posedge clk);
            #1;
            start = 1; step_count = 8'd2; move_out = !dir; recal = 0;
            @(posedge clk); #1;
            start = 0;
        end
        while (!done_seen) @(posedge clk);
        #1;
        chk(falls == exp_steps, rc ? "R8" : "R6", "step count", falls, exp_steps);
        chk(done_err == exp_err, exp_err ? "R9" : "R8", "error flag", done_err, exp_err);
        chk(done_wide == 0, "R7", "done width", done_wide, 0);
        chk(sel_at_done == 1, "R7", "select released at done", sel_at_done, 1);
        chk(dir_bad == 0, "R2", "direction faults", dir_bad, 0);
        if (exp_steps > 0) begin
            chk(first_fall - sel_tick >= 4, "R3", "setup ticks", first_fall - sel_tick, 4);
            chk(width_bad == 0, "R4", "bad pulse widths", width_bad, 0);
            chk(space_bad == 0, "R5", "bad step spacing", space_bad, 0);
            chk(done_tick - last_rise >= 96, "R7", "hold after last rise", done_tick - last_rise, 96);
            chk(done_tick - last_fall >= 20, "R7", "select hold after fall", done_tick - last_fall, 20);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int exp_n;
        void'($urandom(32'd2718));
        clear_stats();
        repeat (3) @(posedge clk);
        #1;
        chk(step_n == 1 && sel_n == 1, "R1", "reset step/select", {step_n, sel_n}, 3);
        chk(busy == 0 && done == 0 && seek_err == 0, "R1", "reset status",
            {busy, done, seek_err}, 0);
        rst_n = 1;
        repeat (4) @(posedge clk);

        // R6: zero count completes in the next cycle, no select, no step.
        @(posedge clk); #1;
        clear_stats();
        start = 1; step_count = '0; move_out = 0; recal = 0;
        @(posedge clk); #1;
        start = 0;
        @(negedge clk); #1;
        chk(done_seen == 1, "R6", "zero count done next cycle", done_seen, 1);
        chk(falls == 0 && sel_seen == 0, "R6", "zero count pulses/select",
            falls + sel_seen, 0);

        // Directed single inward step, then random seeks.
        run_seek(1, 1'b0, 1'b0, 1, 1'b0, 1'b0);
        for (int i = 0; i < 8; i++) begin
            int c = $urandom_range(1, 5);
            bit d = ($urandom_range(0, 2) == 0);
            run_seek(c, d, 1'b0, c, 1'b0, 1'b0);
        end

        // R10: start while busy is ignored, and nothing follows afterwards.
        run_seek(4, 1'b0, 1'b0, 4, 1'b0, 1'b1);
        @(posedge clk); #1;
        clear_stats();
        repeat (40) @(posedge clk);
        #1;
        chk(falls == 0 && sel_seen == 0 && busy == 0, "R10", "no seek after ignored start",
            falls + sel_seen + busy, 0);

        // R8: recalibrate from the current track, then again at track zero.
        exp_n = head;
        run_seek(0, 1'b0, 1'b1, exp_n, 1'b0, 1'b0);
        chk(head == 0, "R8", "head at track zero", head, 0);
        run_seek(3, 1'b0, 1'b1, 0, 1'b0, 1'b0);

        // R8 boundary: exactly 80 steps reach track zero without error.
        run_seek(80, 1'b0, 1'b0, 80, 1'b0, 1'b0);
        run_seek(0, 1'b0, 1'b1, 80, 1'b0, 1'b0);

        // R9: 85 tracks in, recalibrate stops at 80 steps with an error.
        run_seek(85, 1'b0, 1'b0, 85, 1'b0, 1'b0);
        run_seek(0, 1'b0, 1'b1, 80, 1'b1, 1'b0);
        chk(head == 5, "R9", "head after failed recalibrate", head, 5);

        repeat (5) @(posedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule